// File: doc/BRIEF.md
# Keyed Watchdog Timer with Staged NMI and Reset

This block supervises software through a single write-only control port that carries an arm bit and a 3-bit key. While the watchdog is running, software must prove it is alive by writing the bitwise complement of the key currently held. A write with the arm bit set restarts the timeout and the complement becomes the new key. A write with the arm bit clear stops the watchdog. Any other key value is stored as the new key and does not count as a service. So a runaway program that keeps writing one constant cannot keep the watchdog satisfied.

If the first timeout (`ALARM_CYC` clock cycles) passes without a service, the block raises a non-maskable interrupt request and holds it. If a further grace period (`GRACE_CYC` cycles) passes with no service, it emits a one-cycle chip reset request and falls back to the stopped state.

The controller has four states. `WD_IDLE` is the stopped state. `WD_ARMED` counts the first timeout. `WD_ALERT` drives the NMI and counts the grace period. `WD_FIRE` drives the reset pulse. The transitions are:
- start: `WD_IDLE`→`WD_ARMED`.
- restart: `WD_ARMED`/`WD_ALERT`→`WD_ARMED`.
- stop: `WD_ARMED`/`WD_ALERT`→`WD_IDLE`.
- expire: `WD_ARMED`→`WD_ALERT`.
- bite: `WD_ALERT`→`WD_FIRE`.
- recover: `WD_FIRE`→`WD_IDLE`.

Top module: `keyed_wdog`

## Requirements
- R1: After the asynchronous reset the watchdog is stopped, and `running`, `nmi_req` and `rst_req` are all 0.
- R2: While stopped, a write with `wr_arm`=0 has no effect. The watchdog stays stopped and raises no NMI.
- R3: While stopped, a write with `wr_arm`=1 starts the watchdog and stores `wr_key`. With no later service, `nmi_req` first reads 1 in the cycle that follows the `ALARM_CYC`-th clock edge after the write edge.
- R4: While running (counting or in NMI), a write with `wr_arm`=1 and `wr_key` equal to the bitwise NOT of the stored 3-bit key restarts the full `ALARM_CYC` timeout. The written value becomes the stored key.
- R5: While running, a write with `wr_arm`=0 and `wr_key` equal to the bitwise NOT of the stored key stops the watchdog. `running` and `nmi_req` go to 0 after that edge.
- R6: While running, a write with any other key value, whatever `wr_arm` is, replaces the stored key and leaves the timeout running unchanged.
- R7: Once raised, `nmi_req` stays 1 until a restart, a stop or the reset pulse. A restart in the NMI state clears it at the write edge.
- R8: `GRACE_CYC` clock edges after the NMI state is entered, `rst_req` is 1 for exactly one cycle with `nmi_req` 0. The watchdog is then stopped.
- R9: A valid restart that lands on the same edge as the first timeout takes priority, so no NMI is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control register write strobe |
| wr_arm | input | 1 | Written arm bit |
| wr_key | input | 3 | Written key field |
| nmi_req | output | 1 | Non-maskable interrupt request, level |
| rst_req | output | 1 | Chip reset request, one-cycle pulse |
| running | output | 1 | Watchdog running (counting or in NMI) |

## Verification
The bench sweeps every start key against every written key with both arm values, each on a freshly reset block. Only the complement of the start key may restart or stop the watchdog. Every other value must leave the original NMI deadline in place and become the new key, and the bench proves this with a follow-up restart that uses that value's complement. NMI-stage restarts, the full escalation to a reset pulse, idle writes with the arm bit clear, and a restart placed exactly on the expiry edge are also measured as cycle counts. These counts tell apart a timeout that was restarted, one left untouched, and one that was wrongly cleared.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
    localparam int KEY_W = 3;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_ALERT = 2'd2,
        WD_FIRE  = 2'd3
    } wd_state_e;
endpackage

// File: rtl/keyed_wdog_cnt.sv
module keyed_wdog_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/keyed_wdog_key.sv
module keyed_wdog_key
    import keyed_wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [KEY_W-1:0] din,
    output logic             inv_match
);
    logic [KEY_W-1:0] key_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            key_q <= '0;
        else if (ld)
            key_q <= din;
    end

    // a service is recognised only with the complement of the held key
    assign inv_match = (din == ~key_q);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int ALARM_CYC = 10_000_000,
    parameter int GRACE_CYC = 330_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_arm,
    input  logic [KEY_W-1:0] wr_key,
    output logic             nmi_req,
    output logic             rst_req,
    output logic             running
);
    localparam int MAX_CYC = (ALARM_CYC > GRACE_CYC) ? ALARM_CYC : GRACE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC) + 1;
    localparam logic [CNT_W-1:0] ALARM_LD = CNT_W'(ALARM_CYC - 1);
    localparam logic [CNT_W-1:0] GRACE_LD = CNT_W'(GRACE_CYC - 1);

    wd_state_e        state_q, state_d;
    logic             cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0] cnt_val;
    logic             key_ld, key_ok, live;

    assign live = (state_q == WD_ARMED) || (state_q == WD_ALERT);

    keyed_wdog_key u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (key_ld),
        .din       (wr_key),
        .inv_match (key_ok)
    );

    keyed_wdog_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= WD_IDLE;
        else
            state_q <= state_d;
    end

    // next state, counter and key control
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = ALARM_LD;
        cnt_dec  = 1'b0;
        key_ld   = 1'b0;
        unique case (state_q)
            WD_IDLE: begin
                if (wr_en && wr_arm) begin
                    state_d  = WD_ARMED;
                    cnt_load = 1'b1;
                    key_ld   = 1'b1;
                end
            end
            WD_ARMED, WD_ALERT: begin
                key_ld = wr_en;
                if (wr_en && key_ok) begin
                    if (wr_arm) begin
                        state_d  = WD_ARMED;
                        cnt_load = 1'b1;
                    end else begin
                        state_d = WD_IDLE;
                    end
                end else if (cnt_zero) begin
                    if (state_q == WD_ARMED) begin
                        state_d  = WD_ALERT;
                        cnt_load = 1'b1;
                        cnt_val  = GRACE_LD;
                    end else begin
                        state_d = WD_FIRE;
                    end
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            WD_FIRE: state_d = WD_IDLE;
            default: state_d = WD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        nmi_req = (state_q == WD_ALERT);
        rst_req = (state_q == WD_FIRE);
        running = live;
    end
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
    import keyed_wdog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_arm,
    input logic [KEY_W-1:0] wr_key,
    input logic             nmi_req,
    input logic             rst_req,
    input logic             running
);
    p_outputs_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_req && rst_req));

    p_idle_noeffect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !rst_req && wr_en && !wr_arm) |=> (!running && !nmi_req));

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !rst_req && wr_en && wr_arm) |=> (running && !nmi_req));

    p_nmi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !wr_en) |=> (nmi_req || rst_req));

    p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (!rst_req && !running && !nmi_req));

    p_rst_after_nmi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(nmi_req));

    // a key write never touches the controls in a way that lets NMI appear while stopped
    p_nmi_implies_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> running);
endmodule

bind keyed_wdog keyed_wdog_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_arm  (wr_arm),
    .wr_key  (wr_key),
    .nmi_req (nmi_req),
    .rst_req (rst_req),
    .running (running)
);

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
    localparam int ALARM = 8;
    localparam int GRACE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_arm = 1'b0;
    logic [2:0] wr_key = 3'd0;
    logic       nmi_req, rst_req, running;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    keyed_wdog #(.ALARM_CYC(ALARM), .GRACE_CYC(GRACE)) u_keyed_wdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_arm(wr_arm),
        .wr_key(wr_key), .nmi_req(nmi_req), .rst_req(rst_req), .running(running)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive at a negedge, apply on the next posedge, return at the following negedge
    task automatic wr(input logic arm, input logic [2:0] key);
        wr_en = 1'b1; wr_arm = arm; wr_key = key;
        @(posedge clk); #1;
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // counts negedge samples with nmi low, starting at the current one
    task automatic until_nmi(input int lim, output int t);
        t = 0;
        while (!nmi_req && t < lim) begin t++; @(negedge clk); end
    endtask

    initial begin
        int t;
        do_reset();
        check("R1 running", running, 0);
        check("R1 nmi", nmi_req, 0);
        check("R1 rst", rst_req, 0);

        // R2: writes with arm clear while stopped
        for (int k = 0; k < 8; k++) begin
            wr(1'b0, 3'(k));
            until_nmi(ALARM + 3, t);
            check("R2 no nmi", t, ALARM + 3);
            check("R2 stopped", running, 0);
        end

        // R3 + R8: full escalation
        wr(1'b1, 3'd5);
        check("R3 running", running, 1);
        until_nmi(ALARM + 5, t);
        check("R3 nmi delay", t, ALARM);
        t = 0;
        while (!rst_req && t < GRACE + 5) begin
            check("R7 nmi held", nmi_req, 1);
            t++; @(negedge clk);
        end
        check("R8 grace", t, GRACE);
        check("R8 nmi low at pulse", nmi_req, 0);
        @(negedge clk);
        check("R8 one-cycle pulse", rst_req, 0);
        check("R8 stopped", running, 0);

        // R9: restart on the expiry edge
        do_reset();
        wr(1'b1, 3'd2);
        for (int i = 0; i < ALARM - 1; i++) @(negedge clk);
        wr(1'b1, 3'd5);
        check("R9 no nmi", nmi_req, 0);
        until_nmi(ALARM + 5, t);
        check("R9 restarted", t, ALARM);

        // sweep start key s, written key w, arm a
        for (int s = 0; s < 8; s++) begin
            for (int w = 0; w < 8; w++) begin
                for (int a = 0; a < 2; a++) begin
                    do_reset();
                    wr(1'b1, 3'(s));
                    @(negedge clk); @(negedge clk);
                    wr(1'(a), 3'(w));
                    if (3'(w) == ~3'(s)) begin
                        if (a == 1) begin
                            check("R4 running", running, 1);
                            until_nmi(ALARM + 5, t);
                            check("R4 restart delay", t, ALARM);
                            // R4 new key is w: its complement restarts from NMI (R7)
                            wr(1'b1, ~3'(w));
                            check("R7 nmi cleared", nmi_req, 0);
                            until_nmi(ALARM + 5, t);
                            check("R4 key rotated", t, ALARM);
                        end else begin
                            check("R5 stopped", running, 0);
                            until_nmi(ALARM + 3, t);
                            check("R5 no nmi", t, ALARM + 3);
                        end
                    end else begin
                        check("R6 still running", running, 1);
                        until_nmi(ALARM + 5, t);
                        check("R6 deadline kept", t, ALARM - 3);
                        wr(1'b1, ~3'(w));
                        check("R6 key replaced", nmi_req, 0);
                        until_nmi(ALARM + 5, t);
                        check("R6 restart after replace", t, ALARM);
                    end
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule